// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a logical address, given as a 16-bit segment selector and a 32-bit offset, into a 32-bit linear address. Selector bit 2 picks one of two descriptor tables. Each table has its own base and limit inputs. The upper 13 selector bits give the entry number. That number is checked against the chosen table's limit before any memory traffic starts.

If the entry lies inside the table, the block reads the 8-byte descriptor as two 32-bit words over a valid/ready read port. It gathers the segment base from three separate descriptor fields, adds the offset, and reports the sum with a one-cycle done pulse. An entry outside the table produces a one-cycle fault pulse and no read. Only one translation is handled at a time.

Top module: `seg_xlate`

## Requirements
- R1: After reset, done, fault and rd_valid are low.
- R2: Selector bit 2 picks the table. A value of 0 uses the global table inputs (gtab_base, gtab_limit) and a value of 1 uses the local table inputs (ltab_base, ltab_limit).
- R3: The entry number is selector bits 15:3. The low descriptor word is read first, at table base plus entry times 8. The high word is read second, at that address plus 4. Selectors 96, 104, 115 and 123 address global entries 12, 13, 14 and 15.
- R4: Selector bits 1:0 have no effect on the reads or on the result.
- R5: The segment base is made of three fields. Base bits 15:0 come from low word bits 31:16, base bits 23:16 come from high word bits 7:0, and base bits 31:24 come from high word bits 31:24. The linear address is base plus offset, modulo 2^32. A descriptor of 0x00CF9A000000FFFF therefore gives a linear address equal to the offset.
- R6: If entry times 8 plus 7 is greater than the chosen limit, fault pulses and no read is issued. A value equal to the limit is accepted.
- R7: A read word is taken only in a cycle where rd_valid and rd_ready are both high. While rd_ready is low, rd_valid and rd_addr stay unchanged.
- R8: Each translation ends with exactly one single-cycle pulse, either done or fault, never both. lin_addr holds the result while done is high.
- R9: req_valid is ignored while a translation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Starts a translation when the block is idle |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| gtab_base | input | 32 | Global table start address |
| gtab_limit | input | 16 | Global table last valid byte offset |
| ltab_base | input | 32 | Local table start address |
| ltab_limit | input | 16 | Local table last valid byte offset |
| rd_valid | output | 1 | Read request |
| rd_addr | output | 32 | Read word address |
| rd_ready | input | 1 | Read accepted; rd_data valid in the same cycle |
| rd_data | input | 32 | Read data |
| lin_addr | output | 32 | Linear address result |
| done | output | 1 | Translation complete pulse |
| fault | output | 1 | Entry outside table pulse |

## Verification
The assertions assume that the memory side returns rd_data in the same cycle it raises rd_ready. They also assume that the table base and limit inputs do not change during a translation. The bench memory model answers combinationally from rd_addr. The table registers are held constant for the whole run. Requests are issued once per translation, except in one deliberate test that pokes req_valid while the block is busy. The read port is exercised both with rd_ready held high and with rd_ready toggling every cycle.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SELW = 16,
  parameter int LIMW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [SELW-1:0] req_sel,
  input  logic [31:0]     req_off,
  input  logic [31:0]     gtab_base,
  input  logic [LIMW-1:0] gtab_limit,
  input  logic [31:0]     ltab_base,
  input  logic [LIMW-1:0] ltab_limit,
  output logic            rd_valid,
  output logic [31:0]     rd_addr,
  input  logic            rd_ready,
  input  logic [31:0]     rd_data,
  output logic [31:0]     lin_addr,
  output logic            done,
  output logic            fault
);
  localparam int IDXW = SELW - 3;
  localparam int ENDW = (SELW > LIMW) ? SELW : LIMW;

  typedef enum logic [1:0] {S_IDLE, S_CHK, S_LO, S_HI} st_t;

  st_t             st;
  logic [IDXW-1:0] idx_q;
  logic [31:0]     off_q;
  logic [31:0]     tbase_q;
  logic [LIMW-1:0] tlim_q;
  logic [15:0]     blo_q;

  logic [ENDW-1:0] ent_end;
  logic [31:0]     desc_addr;
  logic            xfer;
  logic [31:0]     seg_base;

  assign ent_end   = ENDW'({idx_q, 3'b111});
  assign desc_addr = tbase_q + 32'({idx_q, 3'b000});
  assign rd_valid  = (st == S_LO) || (st == S_HI);
  assign rd_addr   = desc_addr + ((st == S_HI) ? 32'd4 : 32'd0);
  assign xfer      = rd_valid && rd_ready;
  assign seg_base  = {rd_data[31:24], rd_data[7:0], blo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx_q    <= '0;
      off_q    <= '0;
      tbase_q  <= '0;
      tlim_q   <= '0;
      blo_q    <= '0;
      lin_addr <= '0;
      done     <= 1'b0;
      fault    <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          idx_q   <= req_sel[SELW-1:3];
          off_q   <= req_off;
          tbase_q <= req_sel[2] ? ltab_base  : gtab_base;
          tlim_q  <= req_sel[2] ? ltab_limit : gtab_limit;
          st      <= S_CHK;
        end
        S_CHK: begin
          if (ent_end > ENDW'(tlim_q)) begin
            fault <= 1'b1;
            st    <= S_IDLE;
          end else begin
            st <= S_LO;
          end
        end
        S_LO: if (xfer) begin
          blo_q <= rd_data[31:16];
          st    <= S_HI;
        end
        S_HI: if (xfer) begin
          lin_addr <= seg_base + off_q;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [31:0] rd_addr,
  input logic        done,
  input logic        fault
);
  logic hi_phase;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_phase <= 1'b0;
    else if (rd_valid && rd_ready) hi_phase <= ~hi_phase;
  end

  a_r7_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  a_r3_high_word_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !hi_phase |=> rd_valid && rd_addr == $past(rd_addr) + 32'd4);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_fault_single: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  a_r8_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rd_valid && rd_ready) && $past(hi_phase));

  a_r6_no_read_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !rd_valid);
endmodule

bind seg_xlate seg_xlate_chk u_chk (.*);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_sel = '0;
  logic [31:0] req_off = '0;
  logic [31:0] gtab_base = 32'h0000_1000;
  logic [15:0] gtab_limit = 16'h007F;
  logic [31:0] ltab_base = 32'h0000_2000;
  logic [15:0] ltab_limit = 16'h003F;
  logic        rd_valid;
  logic [31:0] rd_addr;
  logic        rd_ready;
  logic [31:0] rd_data;
  logic [31:0] lin_addr;
  logic        done;
  logic        fault;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic stall = 1'b0;
  logic tog   = 1'b0;
  logic [31:0] log_a [256];
  int log_n = 0;

  always #2 clk = ~clk;

  seg_xlate u_seg_xlate (.*);

  function automatic logic [31:0] bbase(input logic ti, input logic [12:0] idx);
    if (!ti && idx >= 13'd12 && idx <= 13'd15) return 32'h0;
    return {ti ? 8'hA5 : 8'h5A, 3'b000, idx, 8'h3C};
  endfunction

  function automatic logic [31:0] mdata(input logic [31:0] a);
    logic ti;
    logic [31:0] tb;
    logic [12:0] idx;
    logic [31:0] b;
    ti  = (a >= 32'h2000);
    tb  = ti ? 32'h2000 : 32'h1000;
    idx = 13'((a - tb) >> 3);
    b   = bbase(ti, idx);
    if (a[2]) return {b[31:24], 8'hCF, (!ti && idx == 13'd12) ? 8'h9A : 8'h92, b[23:16]};
    return {b[15:0], 16'hFFFF};
  endfunction

  assign rd_ready = stall ? tog : 1'b1;
  assign rd_data  = mdata(rd_addr);

  always @(negedge clk) tog <= ~tog;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_valid && rd_ready) begin
      log_a[log_n % 256] <= rd_addr;
      log_n <= log_n + 1;
    end
  end

  initial begin
    wait (cyc > 100000);
    fails++;
    $display("FAIL watchdog: run hung, actual cyc=%0d expected < 100000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // vector: {expect_fault, selector, offset}
  localparam int NV = 12;
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 16'd96,   32'h0814_7258},
    {1'b0, 16'd104,  32'hDEAD_BEEF},
    {1'b0, 16'd115,  32'h0000_0000},
    {1'b0, 16'd123,  32'hFFFF_FFFF},
    {1'b0, 16'h0018, 32'h0000_0100},
    {1'b0, 16'h001B, 32'h0000_0100},
    {1'b0, 16'h0014, 32'h0000_0010},
    {1'b0, 16'h003C, 32'h0000_0020},
    {1'b1, 16'h0044, 32'h0000_0001},
    {1'b1, 16'h0080, 32'h0000_0002},
    {1'b0, 16'h002F, 32'h6FFF_FFFF},
    {1'b0, 16'h0012, 32'h1234_0000}
  };

  task automatic run(input logic [15:0] sel, input logic [31:0] off, input logic efault);
    int n0;
    int w;
    logic ti;
    logic [12:0] idx;
    logic [31:0] ea;
    ti  = sel[2];
    idx = sel[15:3];
    ea  = (ti ? 32'h2000 : 32'h1000) + {16'h0, idx, 3'b000};
    @(negedge clk);
    n0 = log_n;
    req_valid = 1'b1; req_sel = sel; req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!done && !fault && w < 60) begin @(negedge clk); w++; end
    chk(efault ? "R6 fault flag" : "R8 done flag", {31'h0, efault ? fault : done}, 32'h1);
    chk("R8 exclusive", {31'h0, done & fault}, 32'h0);
    if (efault) begin
      chk("R6 no read on fault", log_n - n0, 32'h0);
    end else begin
      chk("R5 linear", lin_addr, bbase(ti, idx) + off);
      chk("R7 two words", log_n - n0, 32'd2);
      chk(ti ? "R2 R3 low word local" : "R2 R3 low word global", log_a[n0 % 256], ea);
      chk("R3 high word", log_a[(n0 + 1) % 256], ea + 32'd4);
    end
    @(negedge clk);
    chk("R8 single pulse", {30'h0, done, fault}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done", {31'h0, done}, 32'h0);
    chk("R1 reset fault", {31'h0, fault}, 32'h0);
    chk("R1 reset rd_valid", {31'h0, rd_valid}, 32'h0);
    rst_n = 1'b1;

    for (int pass = 0; pass < 2; pass++) begin
      stall = (pass == 1);
      for (int i = 0; i < NV; i++) run(VEC[i][47:32], VEC[i][31:0], VEC[i][48]);
    end
    stall = 1'b0;

    // R4: privilege bits change nothing
    run(16'h0019, 32'h55, 1'b0);
    chk("R4 rpl ignored", lin_addr, bbase(1'b0, 13'd3) + 32'h55);

    // R6 boundary on global table: entry 15 end equals limit
    run(16'h0078, 32'h7, 1'b0);

    // R9: request while busy is ignored
    begin
      int n0;
      int w;
      @(negedge clk);
      n0 = log_n;
      stall = 1'b1;
      req_valid = 1'b1; req_sel = 16'd96; req_off = 32'hAAAA_0000;
      @(negedge clk);
      req_sel = 16'h0014; req_off = 32'h0000_BBBB;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      w = 0;
      while (!done && !fault && w < 60) begin @(negedge clk); w++; end
      chk("R9 first request result", lin_addr, 32'hAAAA_0000);
      chk("R9 reads of first request", log_a[n0 % 256], 32'h1000 + 32'd96);
      repeat (12) @(negedge clk);
      chk("R9 no second translation", log_n - n0, 32'd2);
      chk("R9 no extra pulse", {30'h0, done, fault}, 32'h0);
      stall = 1'b0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule